// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command side of a byte-wide flash memory. The host's chip-enable, write-enable and output-enable strobes are sampled by a fast system clock. Write pulses are qualified and turned into command or data writes. These writes drive a small state machine with five functions: reading the byte array, reading a fixed identification pair, two-stage byte programming with a cancel path, software write protection, and status reporting while a program operation runs.

Programming is self-timed. A program takes a parameterised number of clock cycles, and while it runs every read returns status instead of array data. The host can tell the program is done in either of two ways: it can poll bit 7, which reads back inverted until the program ends, or it can watch bit 6, which flips on every read until the program ends. After reset the device is locked against programming. A fixed series of three address/data writes must be written first to unlock it.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, dqOe is 0, dqOut is 00h, and every array byte reads FFh.
- R2: When ceN and oeN are both low, dqOe is 1 and dqOut shows the byte selected by addr. When either ceN or oeN is high, dqOe is 0 and dqOut is 00h.
- R3: Writing command 90h enters ID mode. In ID mode, reads at address 0 return BFh, reads at address 1 return 04h, and reads at any other address return 00h. Writing FFh or 10h leaves ID mode.
- R4: Command 10h arms programming, and the next qualified write programs its address. The new cell value is the old value ANDed with the written data.
- R5: After reset, command 10h is ignored until three writes arrive in order: (5h, AAh), then (Ah, 55h), then (5h, A0h). Any other write in the middle of this series restarts it.
- R6: A write takes its address when ceN and weN are first both low, and takes its data when the first of them rises. A pulse is discarded if oeN is low at any point during it, or if it lasts fewer than MIN_PULSE clock samples.
- R7: Writing FFh while programming is armed cancels the program, leaves the array unchanged and returns to read mode. It does not re-enable protection.
- R8: For PROG_CYCLES cycles after the program write, a read of any address returns status. DQ7 is the complement of bit 7 of the written data, DQ6 inverts on each new read, and bits 5..0 are 0. After that time, reads return array data again.
- R9: Writes made while a program is running are ignored: no command takes effect and the array does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low reset (power-up) |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| dqIn | input | 8 | Data from host |
| dqOut | output | 8 | Data to host |
| dqOe | output | 1 | Drive enable for the data pins |

## Verification
The bench uses AW=4 (sixteen bytes), PROG_CYCLES=40 and MIN_PULSE=4. With sixteen bytes, every address can be programmed twice with patterns computed in the bench, which checks the AND rule across the whole array. With a 40-cycle program time, two status reads and one ignored command fit inside a single busy window. A 2-sample pulse then sits just below the glitch threshold.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_PROG  = 8'h10;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] ID_MAKER  = 8'hBF;
  localparam logic [7:0] ID_DEVICE = 8'h04;

  typedef enum logic [1:0] {ST_RD, ST_ID, ST_ARM, ST_BUSY} ctrlState_t;

  typedef struct packed {
    logic startProg;
    logic commit;
    logic showStatus;
    logic showId;
  } dpCtl_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4,
  parameter int PROG_CYCLES = 40,
  parameter logic [AW-1:0] UA0 = 'h5,
  parameter logic [AW-1:0] UA1 = 'hA,
  parameter logic [AW-1:0] UA2 = 'h5,
  parameter logic [7:0] UD0 = 8'hAA,
  parameter logic [7:0] UD1 = 8'h55,
  parameter logic [7:0] UD2 = 8'hA0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEvt,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  output dpCtl_t        ctl
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [AW-1:0] UL_A [3] = '{UA0, UA1, UA2};
  localparam logic [7:0]    UL_D [3] = '{UD0, UD1, UD2};

  ctrlState_t    state;
  logic          prot;
  logic [1:0]    step;
  logic [TW-1:0] timer;
  logic          stepHit, firstHit;

  assign stepHit  = (wrAddr == UL_A[step]) && (wrData == UL_D[step]);
  assign firstHit = (wrAddr == UL_A[0]) && (wrData == UL_D[0]);

  always_comb begin
    ctl.startProg  = wrEvt && (state == ST_ARM) && (wrData != CMD_RESET);
    ctl.commit     = (state == ST_BUSY) && (timer == '0);
    ctl.showStatus = (state == ST_BUSY);
    ctl.showId     = (state == ST_ID);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RD;
      prot  <= 1'b1;
      step  <= '0;
      timer <= '0;
    end else if (state == ST_BUSY) begin
      if (timer == '0) state <= ST_RD;
      else             timer <= timer - 1'b1;
      if (wrEvt) step <= '0;
    end else if (wrEvt) begin
      if (stepHit) begin
        if (step == 2'd2) begin
          prot <= 1'b0;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        step <= firstHit ? 2'd1 : 2'd0;
      end
      if (state == ST_ARM) begin
        if (wrData == CMD_RESET) state <= ST_RD;
        else begin
          state <= ST_BUSY;
          timer <= TW'(PROG_CYCLES - 1);
        end
      end else if (wrData == CMD_PROG && !prot) state <= ST_ARM;
      else if (wrData == CMD_ID)                state <= ST_ID;
      else if (wrData == CMD_RESET)             state <= ST_RD;
    end
  end

  AST_PROT_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (prot && state != ST_ARM) |=> state != ST_ARM); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && timer == '0) |=> state == ST_RD); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && timer != '0) |=> state == ST_BUSY); // R9
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4,
  parameter int MIN_PULSE = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dqIn,
  input  dpCtl_t        ctl,
  output logic          wrEvt,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData,
  output logic [7:0]    dqOut,
  output logic          dqOe
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = $clog2(MIN_PULSE + 1);

  logic          sCe, sWe, sOe;
  logic [AW-1:0] sAddr, latAddr, tgtAddr;
  logic [7:0]    sDin, tgtData;
  logic          wrOn, wasWr, wrEnd, rdOn, wasRd, toggle;
  logic [PW-1:0] pulseCnt;
  logic [7:0]    mem [DEPTH];

  assign wrOn  = !sCe && !sWe && sOe;
  assign rdOn  = !sCe && !sOe;
  assign wrEnd = wasWr && !wrOn && (sCe || sWe) && sOe && (pulseCnt >= PW'(MIN_PULSE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sCe, sWe, sOe} <= 3'b111;
      sAddr <= '0;
      sDin  <= '0;
    end else begin
      {sCe, sWe, sOe} <= {ceN, weN, oeN};
      sAddr <= addr;
      sDin  <= dqIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wasWr    <= 1'b0;
      wasRd    <= 1'b0;
      pulseCnt <= '0;
      latAddr  <= '0;
      wrEvt    <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      toggle   <= 1'b0;
    end else begin
      wasWr <= wrOn;
      wasRd <= rdOn;
      if (!wrOn)                            pulseCnt <= '0;
      else if (pulseCnt != PW'(MIN_PULSE))  pulseCnt <= pulseCnt + 1'b1;
      if (wrOn && !wasWr) latAddr <= sAddr;
      wrEvt <= wrEnd;
      if (wrEnd) begin
        wrAddr <= latAddr;
        wrData <= sDin;
      end
      if (rdOn && !wasRd && ctl.showStatus) toggle <= ~toggle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      tgtAddr <= '0;
      tgtData <= '0;
    end else begin
      if (ctl.startProg) begin
        tgtAddr <= wrAddr;
        tgtData <= wrData;
      end
      if (ctl.commit) mem[tgtAddr] <= mem[tgtAddr] & tgtData;
    end
  end

  always_comb begin
    dqOe = rdOn;
    if (!rdOn)               dqOut = 8'h00;
    else if (ctl.showStatus) dqOut = {~tgtData[7], toggle, 6'b0};
    else if (ctl.showId)     dqOut = (sAddr == '0) ? ID_MAKER :
                                     (sAddr == AW'(1)) ? ID_DEVICE : 8'h00;
    else                     dqOut = mem[sAddr];
  end

  AST_NO_WR_OE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !sOe |=> !wrEvt); // R6
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    wrEvt |-> $past(pulseCnt) >= PW'(MIN_PULSE)); // R6
  AST_TGT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.showStatus && !ctl.startProg) |=> $stable(tgtData)); // R8
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4,
  parameter int PROG_CYCLES = 40,
  parameter int MIN_PULSE = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dqIn,
  output logic [7:0]    dqOut,
  output logic          dqOe
);
  dpCtl_t        ctl;
  logic          wrEvt;
  logic [AW-1:0] wrAddr;
  logic [7:0]    wrData;

  flash_cmd_ctrl #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEvt(wrEvt), .wrAddr(wrAddr),
    .wrData(wrData), .ctl(ctl));

  flash_cmd_dp #(.AW(AW), .MIN_PULSE(MIN_PULSE)) i_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .ctl(ctl), .wrEvt(wrEvt),
    .wrAddr(wrAddr), .wrData(wrData), .dqOut(dqOut), .dqOe(dqOe));
endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;
  localparam int AW = 4;
  localparam int PC = 40;
  localparam int MP = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, ceN, weN, oeN;
  logic [AW-1:0] addr;
  logic [7:0] dqIn;
  logic [7:0] dqOut;
  logic dqOe;
  int nRun = 0, nFail = 0;
  logic [7:0] model [16];
  logic [7:0] v1, v2;
  logic oe;

  flash_cmd_if #(.AW(AW), .PROG_CYCLES(PC), .MIN_PULSE(MP)) i_flash_cmd_if (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, int len = 8, bit oeLow = 1'b0);
    @(negedge clk);
    addr = a; dqIn = d; oeN = !oeLow; ceN = 1'b0;
    idle(1); weN = 1'b0;
    idle(len); weN = 1'b1;
    idle(1); ceN = 1'b1; oeN = 1'b1;
    idle(4);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v, output logic o);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    idle(3);
    v = dqOut; o = dqOe;
    oeN = 1'b1; ceN = 1'b1;
    idle(2);
  endtask

  task automatic doReset();
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; addr = '0; dqIn = '0;
    idle(3); rstN = 1'b1; idle(2);
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
  endtask

  task automatic unlock();
    wr(4'h5, 8'hAA); wr(4'hA, 8'h55); wr(4'h5, 8'hA0);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d);
    wr(4'h0, 8'h10); wr(a, d); idle(PC + 10);
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    doReset();
    chk("R1 dqOe idle", {7'b0, dqOe}, 8'h00);
    chk("R1 dqOut idle", dqOut, 8'h00);
    rd(4'h3, v1, oe);
    chk("R1 erased", v1, 8'hFF);
    chk("R2 dqOe reading", {7'b0, oe}, 8'h01);
    @(negedge clk); ceN = 1'b1; oeN = 1'b0; idle(3);
    chk("R2 ce high hiz", {7'b0, dqOe}, 8'h00);
    oeN = 1'b1; idle(2);

    // R5: locked after reset
    wr(4'h0, 8'h10); wr(4'h3, 8'h00); idle(PC + 10);
    rd(4'h3, v1, oe); chk("R5 locked program", v1, 8'hFF);

    // R3: ID mode
    wr(4'h0, 8'h90);
    rd(4'h0, v1, oe); chk("R3 maker", v1, 8'hBF);
    rd(4'h1, v1, oe); chk("R3 device", v1, 8'h04);
    rd(4'h2, v1, oe); chk("R3 other", v1, 8'h00);
    wr(4'h0, 8'hFF);
    rd(4'h0, v1, oe); chk("R3 exit", v1, 8'hFF);

    // R5: broken unlock series
    wr(4'h5, 8'hAA); wr(4'hA, 8'h55); wr(4'h3, 8'h11); wr(4'h5, 8'hA0);
    wr(4'h0, 8'h10); wr(4'h3, 8'h00); idle(PC + 10);
    rd(4'h3, v1, oe); chk("R5 deviation", v1, 8'hFF);

    // R7: cancel, then protection still off
    unlock();
    wr(4'h0, 8'h10); wr(4'h0, 8'hFF);
    rd(4'h3, v1, oe); chk("R7 cancel no change", v1, 8'hFF);
    prog(4'h3, 8'h5A);
    rd(4'h3, v1, oe); chk("R7 still unlocked", v1, model[3]);

    // R4: two passes over every address
    for (int a = 0; a < 16; a++) prog(AW'(a), 8'(a * 37 + 11));
    for (int a = 0; a < 16; a++) prog(AW'(a), 8'(a * 91) ^ 8'hC3);
    for (int a = 0; a < 16; a++) begin
      rd(AW'(a), v1, oe); chk("R4 and rule", v1, model[a]);
    end

    // R8/R9: status while busy, command ignored
    wr(4'h0, 8'h10); wr(4'h7, 8'h12);
    rd(4'h9, v1, oe); rd(4'h9, v2, oe);
    chk("R8 poll bit7", {v1[7], 1'b0, v1[5:0]}, 8'h80);
    chk("R8 toggle", {7'b0, v2[6]}, {7'b0, ~v1[6]});
    wr(4'h0, 8'h90);
    idle(PC + 10);
    model[7] = model[7] & 8'h12;
    rd(4'h7, v1, oe); chk("R9 busy write ignored", v1, model[7]);
    chk("R8 done data", v1, model[7]);
    wr(4'h0, 8'h10); wr(4'h8, 8'h80);
    rd(4'h2, v1, oe); chk("R8 poll bit7 set", v1 & 8'hBF, 8'h00);
    idle(PC + 10);
    model[8] = model[8] & 8'h80;

    // R6: OE low and short pulse inhibit
    wr(4'h0, 8'h10); wr(4'h4, 8'h00, 8, 1'b1); idle(PC + 10);
    rd(4'h4, v1, oe); chk("R6 oe low inhibit", v1, model[4]);
    wr(4'h0, 8'hFF);
    wr(4'h0, 8'h10); wr(4'h4, 8'h00, 2); idle(PC + 10);
    rd(4'h4, v1, oe); chk("R6 short pulse", v1, model[4]);
    wr(4'h4, 8'hF0); idle(PC + 10);
    model[4] = model[4] & 8'hF0;
    rd(4'h4, v1, oe); chk("R6 armed after glitch", v1, model[4]);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule